// File: doc/BRIEF.md
# Three-Channel PCM Serial Port

This block moves 8-bit PCM samples for three voice channels between serial lines and parallel words. It runs entirely on the bit clock `bclk`. On the receive side, a rising edge of `rx_sync` marks the first bit of a frame. The block collects one 8-bit sample per channel, most significant bit first, and publishes each finished sample on its own lane of `rx_words`, together with a one-cycle strobe on `rx_valid`.

On the transmit side, a rising edge of `tx_sync` captures the three parallel words on `tx_words`. The block then shifts them out on falling `bclk` edges, so that a receiver can sample each bit on the following rising edge. An output that is not carrying a slot has its drive enable (`tx_en`) low, which means its pad driver is off (high impedance).

`mode_chain` selects between two wirings:
- With `mode_chain` low, each channel has its own receive line and its own transmit line.
- With `mode_chain` high, all three channels run back to back on lane 0, in the order channel 0, channel 1, channel 2. Receive lines 1 and 2 are then ignored, and transmit lanes 1 and 2 stay undriven.

The block also decodes a per-channel power-down flag from a global power-down input and three per-channel control inputs.

Top module: `pcm3_serial_port`

## Requirements
- R1: With `mode_chain`=0, receive lane n shifts `rx_line[n]`. The bit sampled on the first rising `bclk` edge where `rx_sync` is 1 after being 0 on the previous rising edge is bit 7 (MSB) of the slot. The next seven rising edges carry bits 6 down to 0. After the rising edge that samples bit 0, every `rx_valid[n]` is 1 for one cycle, and `rx_words[8n+7:8n]` holds the sample.
- R2: With `mode_chain`=1, `rx_line[0]` carries 24 bits after the sync rise: bits 0..7 are channel 0, bits 8..15 are channel 1 and bits 16..23 are channel 2. `rx_valid[n]` pulses after the last bit of slot n, and `rx_words[8n+7:8n]` then holds that channel's sample.
- R3: With `mode_chain`=1, `rx_line[2:1]` has no effect on `rx_words` or `rx_valid`.
- R4: Bits that arrive after a frame has completed, and before the next sync rise, raise no strobe and leave `rx_words` unchanged.
- R5: A sync rise in the middle of a frame abandons the partial frame. The bit on that edge becomes the MSB of channel 0 of a new frame, and no strobe is raised for any slot of the abandoned frame that was not yet complete.
- R6: `tx_words` is captured on the rising `bclk` edge that sees the `tx_sync` rise. The MSB is driven from the next falling edge. Each bit is held for one full `bclk` period, MSB first. Later changes on `tx_words` do not affect the frame in flight.
- R7: With `mode_chain`=0, lane n sends `tx_words[8n+7:8n]`, and `tx_en` is 3'b111 for exactly 8 bit periods.
- R8: With `mode_chain`=1, lane 0 sends channel 0, then channel 1, then channel 2 over 24 bit periods. `tx_en` is 3'b001 throughout, so lanes 1 and 2 stay at high impedance.
- R9: Outside a slot, `tx_en` is 0 on every lane and `tx_data` is 0.
- R10: `pd_flag[n]` is 1 exactly when `pd_global` is 1 and `pd_ch[n]` is 0.
- R11: Each `rx_valid` bit is high for a single cycle at a time. With `mode_chain`=1, at most one bit of `rx_valid` is high.
- R12: While `rst_n` is low, and after it is released until a sync arrives, `rx_valid`, `rx_words`, `tx_en` and `tx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; data is sampled on rising edges and launched on falling edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_chain | input | 1 | 0: one line pair per channel; 1: three slots back to back on lane 0 |
| rx_sync | input | 1 | Receive frame sync; its rising edge marks the MSB |
| rx_line | input | 3 | Serial receive lines, one per channel |
| rx_words | output | 24 | Received samples; channel n at bits 8n+7:8n |
| rx_valid | output | 3 | One-cycle strobe per channel when its sample completes |
| tx_sync | input | 1 | Transmit frame sync; its rising edge captures `tx_words` |
| tx_words | input | 24 | Samples to send; channel n at bits 8n+7:8n |
| tx_data | output | 3 | Serial transmit data, one per lane |
| tx_en | output | 3 | Drive enable per lane; 0 means high impedance |
| pd_global | input | 1 | Global power-down request |
| pd_ch | input | 3 | Per-channel control; 0 lets the global request power the channel down |
| pd_flag | output | 3 | Decoded power-down flag per channel |

## Verification
The bench goes after a frame that is restarted part way through a slot, and after one restarted on a slot boundary. A design that kept its bit position would strobe a stale channel or mix bits from two frames. Chained frames are sent with random noise on the unused receive lines; a design that listened to those lines in chained mode would publish corrupted words. Transmit words are changed one cycle after the sync, and the lane enables are checked on every bit period. A design that read the words live, or released a lane one period early or late, would send wrong bits or drive a line that should be floating. Trailing bits after each frame confirm that a free-running shifter would be caught strobing outside a slot.

// File: rtl/pcm3_pkg.sv
`timescale 1ns/1ps
package pcm3_pkg;
   typedef enum logic {
      LANE_SPLIT = 1'b0,
      LANE_CHAIN = 1'b1
   } lane_mode_e;
endpackage

// File: rtl/pcm3_rx_framer.sv
`timescale 1ns/1ps
module pcm3_rx_framer #(
   parameter int unsigned NCH       = 3,
   parameter int unsigned SLOT_BITS = 8
) (
   input  logic                      bclk,
   input  logic                      rst_n,
   input  pcm3_pkg::lane_mode_e      mode,
   input  logic                      sync,
   input  logic [NCH-1:0]            line,
   output logic [NCH*SLOT_BITS-1:0]  words,
   output logic [NCH-1:0]            valid
);
   import pcm3_pkg::*;

   localparam int unsigned FRAME_BITS = NCH * SLOT_BITS;
   localparam int unsigned PW = $clog2(FRAME_BITS + 1);
   localparam int unsigned SW = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int unsigned BW = $clog2(SLOT_BITS);

   logic          sync_q;
   logic          active;
   logic [PW-1:0] pos_q;
   logic [PW-1:0] pos_cur;
   logic [PW-1:0] limit;
   logic [SW-1:0] slot;
   logic [BW-1:0] bidx;
   logic          start;
   logic          take;
   logic          last_bit;

   always_comb begin
      start    = sync & ~sync_q;
      take     = start | active;
      pos_cur  = start ? '0 : pos_q;
      limit    = (mode == LANE_CHAIN) ? PW'(FRAME_BITS) : PW'(SLOT_BITS);
      bidx     = BW'(pos_cur % PW'(SLOT_BITS));
      last_bit = take && (bidx == BW'(SLOT_BITS - 1));
   end

   // slot decode only exists when more than one channel shares a line
   if (NCH > 1) begin : g_multi
      assign slot = (mode == LANE_CHAIN) ? SW'(pos_cur / PW'(SLOT_BITS)) : '0;
   end else begin : g_single
      assign slot = '0;
   end

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 1'b0;
         active <= 1'b0;
         pos_q  <= '0;
      end else begin
         sync_q <= sync;
         if (take) begin
            if (pos_cur + 1'b1 == limit) begin
               active <= 1'b0;
               pos_q  <= '0;
            end else begin
               active <= 1'b1;
               pos_q  <= pos_cur + 1'b1;
            end
         end
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_lane
      logic [SLOT_BITS-2:0] shreg;
      logic [SLOT_BITS-1:0] nxt;
      logic [SLOT_BITS-1:0] word_q;
      logic                 valid_q;
      logic                 bit_in;
      logic                 hit;

      always_comb begin
         if (mode == LANE_CHAIN) begin
            bit_in = line[0];
            hit    = take && (slot == SW'(i));
         end else begin
            bit_in = line[i];
            hit    = take;
         end
         nxt = {shreg, bit_in};
      end

      always_ff @(posedge bclk or negedge rst_n) begin
         if (!rst_n) begin
            shreg   <= '0;
            word_q  <= '0;
            valid_q <= 1'b0;
         end else begin
            valid_q <= hit && last_bit;
            if (hit) begin
               shreg <= nxt[SLOT_BITS-2:0];
               if (last_bit) word_q <= nxt;
            end
         end
      end

      assign words[i*SLOT_BITS +: SLOT_BITS] = word_q;
      assign valid[i] = valid_q;
   end
endmodule

// File: rtl/pcm3_tx_serializer.sv
`timescale 1ns/1ps
module pcm3_tx_serializer #(
   parameter int unsigned NCH       = 3,
   parameter int unsigned SLOT_BITS = 8
) (
   input  logic                      bclk,
   input  logic                      rst_n,
   input  pcm3_pkg::lane_mode_e      mode,
   input  logic                      sync,
   input  logic [NCH*SLOT_BITS-1:0]  words_in,
   output logic [NCH-1:0]            tx_data,
   output logic [NCH-1:0]            tx_en
);
   import pcm3_pkg::*;

   localparam int unsigned FRAME_BITS = NCH * SLOT_BITS;
   localparam int unsigned PW = $clog2(FRAME_BITS + 1);
   localparam int unsigned SW = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int unsigned BW = $clog2(SLOT_BITS);
   localparam int unsigned IW = $clog2(FRAME_BITS);

   logic                   sync_q;
   logic                   active;
   logic [PW-1:0]          pos_q;
   logic [PW-1:0]          limit;
   logic [SW-1:0]          slot;
   logic [BW-1:0]          bidx;
   logic [FRAME_BITS-1:0]  words_q;
   logic                   start;

   always_comb begin
      start = sync & ~sync_q;
      limit = (mode == LANE_CHAIN) ? PW'(FRAME_BITS) : PW'(SLOT_BITS);
      bidx  = BW'(pos_q % PW'(SLOT_BITS));
   end

   if (NCH > 1) begin : g_multi
      assign slot = (mode == LANE_CHAIN) ? SW'(pos_q / PW'(SLOT_BITS)) : '0;
   end else begin : g_single
      assign slot = '0;
   end

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q  <= 1'b0;
         active  <= 1'b0;
         pos_q   <= '0;
         words_q <= '0;
      end else begin
         sync_q <= sync;
         if (start) begin
            words_q <= words_in;
            pos_q   <= '0;
            active  <= 1'b1;
         end else if (active) begin
            if (pos_q == limit - 1'b1) begin
               active <= 1'b0;
               pos_q  <= '0;
            end else begin
               pos_q <= pos_q + 1'b1;
            end
         end
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_lane
      logic [SW-1:0] src;
      logic [IW-1:0] sel;
      logic          en_nxt;
      logic          data_q;
      logic          en_q;

      always_comb begin
         if (mode == LANE_CHAIN) begin
            src    = slot;
            en_nxt = active && (i == 0);
         end else begin
            src    = SW'(i);
            en_nxt = active;
         end
         sel = IW'(int'(src) * SLOT_BITS + (SLOT_BITS - 1) - int'(bidx));
      end

      // launch on the falling edge so the far end samples on the rising edge
      always_ff @(negedge bclk or negedge rst_n) begin
         if (!rst_n) begin
            data_q <= 1'b0;
            en_q   <= 1'b0;
         end else begin
            en_q   <= en_nxt;
            data_q <= en_nxt ? words_q[sel] : 1'b0;
         end
      end

      assign tx_data[i] = data_q;
      assign tx_en[i]   = en_q;
   end
endmodule

// File: rtl/pcm3_pd_decode.sv
`timescale 1ns/1ps
module pcm3_pd_decode #(
   parameter int unsigned NCH = 3
) (
   input  logic           pd_global,
   input  logic [NCH-1:0] pd_ch,
   output logic [NCH-1:0] pd_flag
);
   assign pd_flag = {NCH{pd_global}} & ~pd_ch;
endmodule

// File: rtl/pcm3_serial_port.sv
`timescale 1ns/1ps
module pcm3_serial_port #(
   parameter int unsigned NCH       = 3,
   parameter int unsigned SLOT_BITS = 8
) (
   input  logic                      bclk,
   input  logic                      rst_n,
   input  logic                      mode_chain,
   input  logic                      rx_sync,
   input  logic [NCH-1:0]            rx_line,
   output logic [NCH*SLOT_BITS-1:0]  rx_words,
   output logic [NCH-1:0]            rx_valid,
   input  logic                      tx_sync,
   input  logic [NCH*SLOT_BITS-1:0]  tx_words,
   output logic [NCH-1:0]            tx_data,
   output logic [NCH-1:0]            tx_en,
   input  logic                      pd_global,
   input  logic [NCH-1:0]            pd_ch,
   output logic [NCH-1:0]            pd_flag
);
   import pcm3_pkg::*;

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("pcm3_serial_port: NCH must lie in 1..8");
   end
   if (SLOT_BITS < 2 || SLOT_BITS > 32) begin : g_bad_slot
      $error("pcm3_serial_port: SLOT_BITS must lie in 2..32");
   end

   lane_mode_e mode_sel;
   assign mode_sel = mode_chain ? LANE_CHAIN : LANE_SPLIT;

   pcm3_rx_framer #(.NCH(NCH), .SLOT_BITS(SLOT_BITS)) u_rx (
      .bclk  (bclk),
      .rst_n (rst_n),
      .mode  (mode_sel),
      .sync  (rx_sync),
      .line  (rx_line),
      .words (rx_words),
      .valid (rx_valid)
   );

   pcm3_tx_serializer #(.NCH(NCH), .SLOT_BITS(SLOT_BITS)) u_tx (
      .bclk     (bclk),
      .rst_n    (rst_n),
      .mode     (mode_sel),
      .sync     (tx_sync),
      .words_in (tx_words),
      .tx_data  (tx_data),
      .tx_en    (tx_en)
   );

   pcm3_pd_decode #(.NCH(NCH)) u_pd (
      .pd_global (pd_global),
      .pd_ch     (pd_ch),
      .pd_flag   (pd_flag)
   );
endmodule

// File: rtl/pcm3_serial_port_chk.sv
`timescale 1ns/1ps
module pcm3_serial_port_chk #(
   parameter int unsigned NCH       = 3,
   parameter int unsigned SLOT_BITS = 8
) (
   input logic           bclk,
   input logic           rst_n,
   input logic           mode_chain,
   input logic           tx_sync,
   input logic           w0_msb,
   input logic [NCH-1:0] rx_valid,
   input logic [NCH-1:0] tx_data,
   input logic [NCH-1:0] tx_en
);
   if (NCH > 1) begin : g_multi
      AST_CHAIN_TX_HIZ: assert property (@(posedge bclk) disable iff (!rst_n)
         (mode_chain && $past(mode_chain)) |-> (tx_en[NCH-1:1] == '0)); // R8
      AST_CHAIN_ONE_VALID: assert property (@(posedge bclk) disable iff (!rst_n)
         (mode_chain && $past(mode_chain)) |-> $onehot0(rx_valid)); // R11
   end

   AST_VALID_PULSE: assert property (@(posedge bclk) disable iff (!rst_n)
      (|rx_valid) |=> ((rx_valid & $past(rx_valid)) == '0)); // R11

   AST_TX_MSB_FIRST: assert property (@(posedge bclk) disable iff (!rst_n)
      $rose(tx_sync) |=> (tx_en[0] && (tx_data[0] == $past(w0_msb)))); // R6
endmodule

bind pcm3_serial_port pcm3_serial_port_chk #(.NCH(NCH), .SLOT_BITS(SLOT_BITS)) u_chk (
   .bclk       (bclk),
   .rst_n      (rst_n),
   .mode_chain (mode_chain),
   .tx_sync    (tx_sync),
   .w0_msb     (tx_words[SLOT_BITS-1]),
   .rx_valid   (rx_valid),
   .tx_data    (tx_data),
   .tx_en      (tx_en)
);

// File: tb/pcm3_serial_port_bench.sv
`timescale 1ns/1ps
module pcm3_serial_port_bench;
   localparam int NCH = 3;
   localparam int W   = 8;
   localparam int FB  = NCH * W;

   logic           bclk = 1'b0;
   logic           rst_n = 1'b0;
   logic           mode_chain = 1'b0;
   logic           rx_sync = 1'b0;
   logic           tx_sync = 1'b0;
   logic           pd_global = 1'b0;
   logic [NCH-1:0] rx_line = '0;
   logic [NCH-1:0] pd_ch = '0;
   logic [FB-1:0]  tx_words = '0;
   wire  [FB-1:0]  rx_words;
   wire  [NCH-1:0] rx_valid, tx_data, tx_en, pd_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [FB-1:0] exp_words = '0;

   always #10 bclk = ~bclk;

   pcm3_serial_port u_pcm3_serial_port (
      .bclk(bclk), .rst_n(rst_n), .mode_chain(mode_chain),
      .rx_sync(rx_sync), .rx_line(rx_line), .rx_words(rx_words), .rx_valid(rx_valid),
      .tx_sync(tx_sync), .tx_words(tx_words), .tx_data(tx_data), .tx_en(tx_en),
      .pd_global(pd_global), .pd_ch(pd_ch), .pd_flag(pd_flag)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic to_drive();
      @(negedge bclk); #2;
   endtask

   task automatic to_sample();
      @(posedge bclk); #3;
   endtask

   function automatic logic wbit(input logic [FB-1:0] ws, input int ch, input int o);
      return ws[ch*W + W-1-o];
   endfunction

   // r > 0 inserts a second sync rise at cycle r carrying frame wb
   task automatic rx_run(input bit chain, input int r,
                         input logic [FB-1:0] wa, input logic [FB-1:0] wb);
      int lim;
      int last;
      string tag;
      lim  = chain ? FB : W;
      last = r + lim + 4;
      tag  = (r > 0) ? "R5" : (chain ? "R2" : "R1");
      to_drive();
      mode_chain = chain;
      rx_sync = 1'b0;
      for (int c = 0; c <= last; c++) begin
         int fs;
         int o;
         logic [FB-1:0] ws;
         logic [NCH-1:0] ln;
         logic [NCH-1:0] ev;
         fs = (r > 0 && c >= r) ? r : 0;
         o  = c - fs;
         ws = (r > 0 && c >= r) ? wb : wa;
         ln = NCH'($urandom);
         if (o < lim) begin
            if (chain) ln[0] = wbit(ws, o / W, o % W);
            else for (int i = 0; i < NCH; i++) ln[i] = wbit(ws, i, o);
         end
         ev = '0;
         if (o < lim && (o % W) == W-1) begin
            if (chain) ev[o / W] = 1'b1;
            else ev = '1;
         end
         to_drive();
         rx_sync = (c == 0) || (r > 0 && c == r);
         rx_line = ln;
         to_sample();
         for (int i = 0; i < NCH; i++)
            if (ev[i]) exp_words[i*W +: W] = ws[i*W +: W];
         if (o >= lim) check("R4", "strobe after frame end", 32'(rx_valid), 32'(ev));
         else          check(tag, "rx_valid per bit", 32'(rx_valid), 32'(ev));
      end
      check(chain ? "R3" : "R4", "rx_words after frame", 32'(rx_words), 32'(exp_words));
      to_drive();
      rx_sync = 1'b0;
      rx_line = '0;
   endtask

   task automatic tx_run(input bit chain, input logic [FB-1:0] ws);
      int lim;
      lim = chain ? FB : W;
      to_drive();
      mode_chain = chain;
      tx_sync = 1'b1;
      tx_words = ws;
      to_sample();
      check("R9", "tx_en before first launch", 32'(tx_en), 32'd0);
      to_drive();
      tx_sync = 1'b0;
      tx_words = FB'($urandom);
      for (int c = 1; c <= lim + 3; c++) begin
         int o;
         logic [NCH-1:0] een;
         logic [NCH-1:0] edat;
         o = c - 1;
         een = '0;
         edat = '0;
         if (o < lim) begin
            if (chain) begin
               een = 3'b001;
               edat[0] = wbit(ws, o / W, o % W);
            end else begin
               een = '1;
               for (int i = 0; i < NCH; i++) edat[i] = wbit(ws, i, o);
            end
         end
         if (c > 1) to_drive();
         to_sample();
         if (o >= lim) begin
            check("R9", "tx_en idle", 32'(tx_en), 32'(een));
            check("R9", "tx_data idle", 32'(tx_data), 32'(edat));
         end else begin
            check(chain ? "R8" : "R7", "tx_en in slot", 32'(tx_en), 32'(een));
            check("R6", "tx_data bit", 32'(tx_data), 32'(edat));
         end
      end
   endtask

   task automatic pd_try(input logic g, input logic [NCH-1:0] ch);
      logic [NCH-1:0] e;
      to_drive();
      pd_global = g;
      pd_ch = ch;
      #1;
      for (int i = 0; i < NCH; i++) e[i] = g & ~ch[i];
      check("R10", "pd_flag decode", 32'(pd_flag), 32'(e));
   endtask

   initial begin
      #4000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge bclk);
      #3;
      check("R12", "rx_valid in reset", 32'(rx_valid), 32'd0);
      check("R12", "tx_en in reset", 32'(tx_en), 32'd0);
      to_drive();
      rst_n = 1'b1;
      to_sample();
      to_sample();
      check("R12", "rx_words after reset", 32'(rx_words), 32'd0);
      check("R12", "rx_valid after reset", 32'(rx_valid), 32'd0);
      check("R12", "tx_data after reset", 32'(tx_data), 32'd0);

      // directed receive cases
      rx_run(1'b0, 0, 24'hA5_00_FF, '0);
      rx_run(1'b1, 0, 24'h81_7E_3C, '0);
      rx_run(1'b1, 10, 24'h12_34_56, 24'hC3_99_0F);   // restart inside channel 1
      rx_run(1'b1, 16, 24'hFE_DC_BA, 24'h01_80_55);   // restart on slot 2 boundary
      rx_run(1'b0, 5, 24'h11_22_33, 24'hE7_5A_24);    // restart mid slot, split mode

      // directed transmit cases
      tx_run(1'b0, 24'h80_01_FF);
      tx_run(1'b1, 24'h5A_A5_C3);

      // random mix
      for (int k = 0; k < 4; k++) begin
         rx_run(1'b0, 0, FB'($urandom), '0);
         rx_run(1'b1, 0, FB'($urandom), '0);
         tx_run(1'b0, FB'($urandom));
         tx_run(1'b1, FB'($urandom));
      end

      pd_try(1'b0, 3'b000);
      pd_try(1'b1, 3'b000);
      pd_try(1'b1, 3'b111);
      pd_try(1'b1, 3'b010);
      for (int k = 0; k < 12; k++) pd_try(1'($urandom), NCH'($urandom));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule